// File: doc/BRIEF.md
# Configurable-Frame Serial UART

A full-duplex asynchronous serial port in which the character frame is set at run time. A frame is one low start bit, 5 to 9 data bits sent least significant bit first, an optional parity bit, and a stop period of 0.5, 1, 1.5 or 2 bit times. The frame settings are captured from configuration inputs by a write strobe. A divisor register, loaded at reset with a value computed from the clock and baud parameters and writable afterwards, produces a tick that runs at 16 times the bit rate. Transmitter and receiver both time their bits from this tick.

The host side has a valid/ready transmit port and a valid/ready receive port. Each is one holding stage wide. The received word comes with its parity-error and framing-error flags. Optional hardware flow control works with an active-high clear-to-send input and an active-high request-to-send output. A wake output gives a single-cycle pulse on the first falling edge of the receive line once wake is enabled. It is meant to bring the host out of a low-power state.

Top module: `uart_cfg_frame`

## Requirements
- R1: After reset, txd_o is 1, tx_ready_o is 1, rx_valid_o is 0, rts_o is 1 and wake_o is 0. The frame is 8 data bits, no parity and 1 stop bit.
- R2: One bit lasts 16 ticks, and one tick lasts div clock cycles. The divisor resets to CLK_HZ/(16*BAUD), which is 2 with the defaults. div_we_i loads div_i, and a value of 0 is taken as 1.
- R3: A transmitted frame is a 0 start bit, then the data bits LSB first, then the parity bit if parity is enabled, then a stop level of 1.
- R4: parity_i code: 0 none, 1 odd (data plus parity has an odd number of ones), 2 even, 3 mark (bit is always 1), 4 space (bit is always 0). Codes 5 to 7 are taken as none.
- R5: stop_i code: 0 gives 0.5, 1 gives 1, 2 gives 1.5 and 3 gives 2 bit times, timed in steps of 8 ticks. A frame takes 16*(1+width+parity)+8*(code+1) ticks.
- R6: dbits_i gives the data width, 5 to 9; any other value is taken as 8. tx_data_i bits at or above the width are ignored, and the same bits of rx_data_o read 0.
- R7: When flow_en_i is 1 and cts_i is 0, tx_ready_o is 0 and no frame starts. txd_o stays 1.
- R8: When flow_en_i is 1, rts_o is 0 while a received word is waiting unread. When flow_en_i is 0, rts_o is 1.
- R9: The receiver samples each bit at its middle tick. A start level that is gone by mid-bit is rejected. A received word holds on rx_data_o with rx_valid_o until rx_ready_i, and a frame that ends while a word is held is dropped.
- R10: rx_par_err_o is 1 when the received parity bit differs from the one the mode expects. rx_frm_err_o is 1 when the first stop sample is 0. Both flags belong to the word on rx_data_o.
- R11: While wake_en_i is 1, the first falling edge on rxd_i produces a one-cycle pulse on wake_o. Further edges give no pulse until wake_en_i goes to 0 and back to 1.
- R12: parity_i, stop_i and dbits_i take effect only on a cycle with cfg_we_i, and must change only while both directions are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 1 | Load strobe for the divisor |
| div_i | input | DIV_W | New divisor: clock cycles per tick |
| cfg_we_i | input | 1 | Capture strobe for the frame settings |
| parity_i | input | 3 | Parity mode code |
| stop_i | input | 2 | Stop length code |
| dbits_i | input | 4 | Data width, 5 to 9 |
| flow_en_i | input | 1 | Hardware flow control enable |
| cts_i | input | 1 | Peer is ready to accept data (active high) |
| rts_o | output | 1 | This side is ready to accept data (active high) |
| tx_data_i | input | 9 | Word to transmit |
| tx_valid_i | input | 1 | Transmit word is valid |
| tx_ready_o | output | 1 | Transmitter accepts a word |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rx_data_o | output | 9 | Received word, right aligned |
| rx_valid_o | output | 1 | A received word is held |
| rx_ready_i | input | 1 | Host takes the held word |
| rx_par_err_o | output | 1 | Parity error on the held word |
| rx_frm_err_o | output | 1 | Framing error on the held word |
| wake_en_i | input | 1 | Arms the wake detector |
| wake_o | output | 1 | Wake pulse |

## Verification
On acceptance, tx_ready_o drops and txd_o falls at the same edge. After that, bit k of the frame is stable around 8*div + 16*k*div cycles from that edge, and tx_ready_o returns within div cycles of the nominal frame length. The bench samples each bit at that mid point and checks the frame length inside a window one divisor wide. The receiver flags rx_valid_o at its mid-stop sample. That sample falls before the transmitter ends the stop period, or within one bit time after the bench stops driving a frame, so the bench reads the holding stage only after the frame is complete. wake_o rises three cycles after a falling edge on rxd_i. The bench therefore counts pulses over windows of many bit times rather than sampling a single cycle.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int DATA_W = 9;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_e;

  typedef struct packed {
    par_e       par;
    logic [1:0] stop;
    logic [3:0] dbits;
  } frame_cfg_t;

  function automatic frame_cfg_t norm_cfg(input logic [2:0] p, input logic [1:0] s,
                                          input logic [3:0] d);
    frame_cfg_t c;
    c.par   = (p > 3'd4) ? PAR_NONE : par_e'(p);
    c.stop  = s;
    c.dbits = (d < 4'd5 || d > 4'd9) ? 4'd8 : d;
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] dmask(input logic [3:0] d);
    return 9'h1FF >> (4'd9 - d);
  endfunction

  function automatic logic par_bit(input par_e p, input logic [DATA_W-1:0] v);
    case (p)
      PAR_ODD:  return ~^v;
      PAR_EVEN: return ^v;
      PAR_MARK: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  // stop period in ticks: 8 per half bit
  function automatic logic [5:0] stop_len(input logic [1:0] s);
    return {({1'b0, s} + 3'd1), 3'b000};
  endfunction
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV_W   = 16,
  parameter int RST_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] RstDiv = (RST_DIV < 1) ? DIV_W'(1) : DIV_W'(RST_DIV);

  logic [DIV_W-1:0] div_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= RstDiv;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      if (div_we_i) div_q <= (div_i == '0) ? DIV_W'(1) : div_i;
      if (cnt_q >= div_q - DIV_W'(1)) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + DIV_W'(1);
        tick_o <= 1'b0;
      end
    end
  end

  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_q > DIV_W'(1) && !div_we_i) |=> !tick_o);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  frame_cfg_t        cfg_i,
  input  logic              flow_en_i,
  input  logic              cts_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_e;

  tx_st_e            st_q;
  logic [5:0]        tc_q;
  logic [3:0]        idx_q;
  logic [DATA_W-1:0] sh_q, din_m;
  logic              pb_q, go, last;

  assign ready_o = (st_q == T_IDLE) && !(flow_en_i && !cts_i);
  assign go      = valid_i && ready_o;
  assign din_m   = data_i & dmask(cfg_i.dbits);
  assign last    = (st_q == T_STOP) ? (tc_q == stop_len(cfg_i.stop) - 6'd1) : (tc_q == 6'd15);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= T_IDLE;
      tc_q  <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      pb_q  <= 1'b0;
    end else if (go) begin
      st_q  <= T_START;
      tc_q  <= '0;
      idx_q <= '0;
      sh_q  <= din_m;
      pb_q  <= par_bit(cfg_i.par, din_m);
    end else if (tick_i && st_q != T_IDLE) begin
      if (!last) begin
        tc_q <= tc_q + 6'd1;
      end else begin
        tc_q <= '0;
        case (st_q)
          T_START: st_q <= T_DATA;
          T_DATA: begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 4'd1;
            if (idx_q == cfg_i.dbits - 4'd1)
              st_q <= (cfg_i.par == PAR_NONE) ? T_STOP : T_PAR;
          end
          T_PAR:   st_q <= T_STOP;
          default: st_q <= T_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st_q)
      T_START: txd_o = 1'b0;
      T_DATA:  txd_o = sh_q[0];
      T_PAR:   txd_o = pb_q;
      default: txd_o = 1'b1;
    endcase
  end

  p_cts_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_IDLE && flow_en_i && !cts_i) |=> (st_q == T_IDLE && txd_o));
  p_start_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!txd_o && !ready_o));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  frame_cfg_t        cfg_i,
  input  logic              rxd_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              fall_o
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_e;

  rx_st_e            st_q;
  logic              s1_q, s2_q, s3_q, prx_q;
  logic [3:0]        tc_q, idx_q, stop_pt;
  logic [DATA_W-1:0] sh_q, aligned;
  logic              mid, done;

  assign fall_o  = s3_q & ~s2_q;
  // half-bit stop is sampled at its own middle
  assign stop_pt = (cfg_i.stop == 2'd0) ? 4'd11 : 4'd15;
  assign mid     = (st_q == R_START && tc_q == 4'd7) || (st_q == R_STOP && tc_q == stop_pt)
                || ((st_q == R_DATA || st_q == R_PAR) && tc_q == 4'd15);
  assign done    = tick_i && st_q == R_STOP && tc_q == stop_pt;
  assign aligned = sh_q >> (4'd9 - cfg_i.dbits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= R_IDLE;
      tc_q  <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      prx_q <= 1'b0;
    end else if (st_q == R_IDLE) begin
      if (!s2_q) begin
        st_q <= R_START;
        tc_q <= '0;
      end
    end else if (tick_i) begin
      if (!mid) begin
        tc_q <= tc_q + 4'd1;
      end else begin
        tc_q <= '0;
        case (st_q)
          R_START: begin
            st_q  <= s2_q ? R_IDLE : R_DATA;
            idx_q <= '0;
          end
          R_DATA: begin
            sh_q  <= {s2_q, sh_q[DATA_W-1:1]};
            idx_q <= idx_q + 4'd1;
            if (idx_q == cfg_i.dbits - 4'd1)
              st_q <= (cfg_i.par == PAR_NONE) ? R_STOP : R_PAR;
          end
          R_PAR: begin
            prx_q <= s2_q;
            st_q  <= R_STOP;
          end
          default: st_q <= R_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else if (done && (!valid_o || rd_i)) begin
      data_o  <= aligned;
      perr_o  <= (cfg_i.par != PAR_NONE) && (prx_q != par_bit(cfg_i.par, aligned));
      ferr_o  <= !s2_q;
      valid_o <= 1'b1;
    end else if (rd_i) begin
      valid_o <= 1'b0;
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rd_i) |=> (valid_o && $stable(data_o)));
  p_glitch_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == R_START && tick_i && tc_q == 4'd7 && s2_q) |=> (st_q == R_IDLE));
endmodule

// File: rtl/uart_cfg_frame.sv
module uart_cfg_frame
  import uart_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int BAUD   = 3_906_250,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        parity_i,
  input  logic [1:0]        stop_i,
  input  logic [3:0]        dbits_i,
  input  logic              flow_en_i,
  input  logic              cts_i,
  output logic              rts_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              rx_par_err_o,
  output logic              rx_frm_err_o,
  input  logic              wake_en_i,
  output logic              wake_o
);
  localparam int RstDiv = CLK_HZ / (16 * BAUD);

  frame_cfg_t cfg_q;
  logic       tick, rx_fall, fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '{par: PAR_NONE, stop: 2'd1, dbits: 4'd8};
    else if (cfg_we_i) cfg_q <= norm_cfg(parity_i, stop_i, dbits_i);
  end

  uart_tick_gen #(.DIV_W(DIV_W), .RST_DIV(RstDiv)) u_tick (
    .clk_i, .rst_ni, .div_we_i, .div_i, .tick_o(tick)
  );

  uart_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg_q), .flow_en_i, .cts_i,
    .data_i(tx_data_i), .valid_i(tx_valid_i), .ready_o(tx_ready_o), .txd_o
  );

  uart_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg_q), .rxd_i, .rd_i(rx_ready_i),
    .data_o(rx_data_o), .valid_o(rx_valid_o), .perr_o(rx_par_err_o),
    .ferr_o(rx_frm_err_o), .fall_o(rx_fall)
  );

  assign rts_o = !(flow_en_i && rx_valid_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      wake_o  <= 1'b0;
    end else begin
      wake_o <= wake_en_i && rx_fall && !fired_q;
      if (!wake_en_i)   fired_q <= 1'b0;
      else if (rx_fall) fired_q <= 1'b1;
    end
  end

  p_wake_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  p_wake_needs_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_en_i |=> !wake_o);
endmodule

// File: tb/uart_cfg_frame_bench.sv
module uart_cfg_frame_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_we = 1'b0, cfg_we = 1'b0;
  logic [15:0] div = 16'd2;
  logic [2:0] par = 3'd0;
  logic [1:0] stp = 2'd1;
  logic [3:0] dbits = 4'd8;
  logic       flow_en = 1'b0, cts = 1'b1, rts;
  logic [8:0] tx_data = '0;
  logic       tx_valid = 1'b0, tx_ready, txd;
  logic       loop_en = 1'b1, rx_drv = 1'b1, rx_line;
  logic [8:0] rx_data;
  logic       rx_valid, rx_ready = 1'b0, perr, ferr;
  logic       wake_en = 1'b0, wake;
  int         n_chk = 0, n_fail = 0, wake_cnt = 0;
  bit         finished = 0;

  always #4 clk = ~clk;
  assign rx_line = loop_en ? txd : rx_drv;

  uart_cfg_frame u_uart_cfg_frame (
    .clk_i(clk), .rst_ni(rst_n), .div_we_i(div_we), .div_i(div), .cfg_we_i(cfg_we),
    .parity_i(par), .stop_i(stp), .dbits_i(dbits), .flow_en_i(flow_en), .cts_i(cts),
    .rts_o(rts), .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .txd_o(txd), .rxd_i(rx_line), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .rx_par_err_o(perr), .rx_frm_err_o(ferr),
    .wake_en_i(wake_en), .wake_o(wake)
  );

  always @(negedge clk) if (wake) wake_cnt++;

  // {parity[26:24], stop[23:22], dbits[21:18], data_in[17:9], data_expected[8:0]}
  localparam logic [26:0] VEC [6] = '{
    {3'd0, 2'd1, 4'd8, 9'h0A5, 9'h0A5},
    {3'd1, 2'd0, 4'd5, 9'h1F3, 9'h013},
    {3'd2, 2'd2, 4'd7, 9'h07F, 9'h07F},
    {3'd3, 2'd3, 4'd9, 9'h155, 9'h155},
    {3'd4, 2'd1, 4'd6, 9'h02C, 9'h02C},
    {3'd2, 2'd3, 4'd9, 9'h1FF, 9'h1FF}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_par(input int p, input int v, input int w);
    int ones = 0;
    for (int i = 0; i < w; i++) ones += (v >> i) & 1;
    case (p)
      1: return (ones % 2 == 0) ? 1 : 0;
      2: return ones % 2;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic set_cfg(input int p, input int s, input int d);
    @(negedge clk);
    par = 3'(p); stp = 2'(s); dbits = 4'(d); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  // send one word, decode the line, check length and the looped-back word
  task automatic send_tx(input int data, input int w, input int p, input int s,
                         input int d, input int expd);
    int cyc = 0, got = 0, nt, hp;
    logic [15:0] bits = '1;
    hp = (p != 0) ? 1 : 0;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = 9'(data); tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    while (!tx_ready) begin
      @(negedge clk);
      cyc++;
      if (cyc % (16 * d) == 8 * d && cyc / (16 * d) < 16) bits[cyc / (16 * d)] = txd;
    end
    nt = 16 * (1 + w + hp) + 8 * (s + 1);
    for (int i = 0; i < w; i++) got |= int'(bits[1 + i]) << i;
    chk("R3", "start bit", int'(bits[0]), 0);
    chk("R3/R6", "tx data LSB first", got, expd);
    if (hp != 0) chk("R4", "parity bit", int'(bits[1 + w]), exp_par(p, expd, w));
    if (s != 0) chk("R3", "stop level", int'(bits[1 + w + hp]), 1);
    chk("R5", "frame length in window", int'(cyc > nt * d - d && cyc <= nt * d), 1);
    chk("R9", "loopback valid", int'(rx_valid), 1);
    chk("R9/R6", "loopback data", int'(rx_data), expd);
    chk("R10", "loopback no errors", int'({perr, ferr}), 0);
    rd();
  endtask

  task automatic drive_rx(input int v, input int w, input int hp, input int pb,
                          input int stop_hi, input int d);
    rx_drv = 1'b0;
    repeat (16 * d) @(negedge clk);
    for (int i = 0; i < w; i++) begin
      rx_drv = 1'((v >> i) & 1);
      repeat (16 * d) @(negedge clk);
    end
    if (hp != 0) begin
      rx_drv = 1'(pb);
      repeat (16 * d) @(negedge clk);
    end
    rx_drv = 1'(stop_hi);
    repeat ((stop_hi != 0) ? 16 * d : 12 * d) @(negedge clk);
    rx_drv = 1'b1;
    repeat (16 * d) @(negedge clk);
  endtask

  task automatic rx_fall_pulse();
    rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (80) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    int lows;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "txd idle", int'(txd), 1);
    chk("R1", "tx_ready", int'(tx_ready), 1);
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "rts", int'(rts), 1);
    chk("R1", "wake", int'(wake), 0);

    // R1/R2: default frame 8N1 with reset divisor 2
    send_tx(9'h03C, 8, 0, 1, 2, 9'h03C);

    // table walk: R3 R4 R5 R6 R9 R10
    for (int i = 0; i < 6; i++) begin
      set_cfg(int'(VEC[i][26:24]), int'(VEC[i][23:22]), int'(VEC[i][21:18]));
      send_tx(int'(VEC[i][17:9]), int'(VEC[i][21:18]), int'(VEC[i][26:24]),
              int'(VEC[i][23:22]), 2, int'(VEC[i][8:0]));
    end

    // R4/R6/R12: illegal codes fall back to none and 8 bits
    set_cfg(7, 1, 12);
    send_tx(9'h1C3, 8, 0, 1, 2, 9'h0C3);

    // R2: divisor 3
    @(negedge clk); div = 16'd3; div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;
    send_tx(9'h05A, 8, 0, 1, 3, 9'h05A);
    @(negedge clk); div = 16'd2; div_we = 1'b1;
    @(negedge clk); div_we = 1'b0;

    // R7: CTS holds the transmitter
    flow_en = 1'b1; cts = 1'b0; tx_data = 9'h0FF; tx_valid = 1'b1;
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!txd || tx_ready) lows++;
    end
    chk("R7", "no start while CTS low", lows, 0);
    tx_valid = 1'b0; cts = 1'b1;
    send_tx(9'h0E1, 8, 0, 1, 2, 9'h0E1);

    // receive path driven by bench
    loop_en = 1'b0;
    // R9: start glitch rejected
    rx_drv = 1'b0;
    repeat (6) @(negedge clk);
    rx_drv = 1'b1;
    repeat (80) @(negedge clk);
    chk("R9", "glitch gives no word", int'(rx_valid), 0);

    // R8/R9: RTS and hold/drop
    drive_rx(9'h011, 8, 0, 0, 1, 2);
    chk("R8", "rts low while full", int'(rts), 0);
    chk("R9", "held word", int'(rx_data), 9'h011);
    drive_rx(9'h022, 8, 0, 0, 1, 2);
    chk("R9", "second frame dropped", int'(rx_data), 9'h011);
    chk("R9", "still valid", int'(rx_valid), 1);
    rd();
    chk("R9", "valid clears on read", int'(rx_valid), 0);
    chk("R8", "rts high after read", int'(rts), 1);
    flow_en = 1'b0;
    drive_rx(9'h033, 8, 0, 0, 1, 2);
    chk("R8", "rts high with flow off", int'(rts), 1);
    rd();

    // R10: parity error (even, 0x03 needs 0, send 1)
    set_cfg(2, 1, 8);
    drive_rx(9'h003, 8, 1, 1, 1, 2);
    chk("R10", "parity error flagged", int'(perr), 1);
    chk("R10", "no framing error", int'(ferr), 0);
    chk("R10", "data with parity error", int'(rx_data), 9'h003);
    rd();
    // R10: framing error
    set_cfg(0, 1, 8);
    drive_rx(9'h05A, 8, 0, 0, 0, 2);
    chk("R10", "framing error flagged", int'(ferr), 1);
    chk("R10", "no parity error", int'(perr), 0);
    rd();
    repeat (64) @(negedge clk);
    chk("R10", "no spurious word after bad stop", int'(rx_valid), 0);

    // R11: wake pulse
    wake_cnt = 0;
    wake_en = 1'b1;
    repeat (4) @(negedge clk);
    rx_fall_pulse();
    rx_fall_pulse();
    chk("R11", "single wake pulse", wake_cnt, 1);
    wake_en = 1'b0;
    repeat (4) @(negedge clk);
    rx_fall_pulse();
    chk("R11", "no wake when disabled", wake_cnt, 1);
    wake_en = 1'b1;
    repeat (4) @(negedge clk);
    rx_fall_pulse();
    chk("R11", "re-armed wake", wake_cnt, 2);
    chk("R9", "wake edges leave no word", int'(rx_valid), 0);

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end
endmodule